// File: doc/BRIEF.md
# 8-bit Add/Subtract Unit with Flag Register

This block is the arithmetic core of a small 8-bit processor datapath. It adds or subtracts two 8-bit operands, with or without an incoming carry, and produces the 8-bit result in the same cycle. On any clock edge where the execute strobe is high, four status flags are captured into a register: zero, subtract, half-carry and carry. One adder serves all four operations. For subtraction, the second operand goes through a row of inverters and the adder's carry input supplies the missing +1. No separate negation stage exists.

A mode pin selects how the carry flag is read during subtraction. In borrow mode the carry flag stands for "a borrow happened". The stored flag is inverted before it enters the adder, and both adder carries are inverted before they are stored. In direct mode the carry flag stands for "no borrow". Only the operand is inverted, and the carry passes through unchanged in both directions. Addition is the same in both modes.

The operands and the result are plain combinational pins with no handshake. The block accepts a new operation on every cycle and never applies back-pressure. The caller samples `result` in the cycle the inputs are applied, and reads the flags one edge after the strobe.

Top module: `addsub_alu8`

## Requirements
- R1: Operation code `op` is 2'b00 ADD (carry-in 0) or 2'b01 ADC (carry-in = stored carry flag). For both, `result` is the low 8 bits of the sum. After an executed edge, `flag_c` is the carry out of bit 7 and `flag_h` is the carry out of bit 3, both uninverted, in either mode.
- R2: Code 2'b10 is SUB. With `borrow_mode`=1 it computes opa + ~opb + 1. The flags are inverted adder carries: `flag_c` = NOT(carry out of bit 7) and `flag_h` = NOT(carry out of bit 3). Examples: 0x90−0x92 gives 0xFE with C=1 and H=1; 0x34−0x12 gives 0x22 with C=0.
- R3: Code 2'b11 is SBC. With `borrow_mode`=1 the stored carry flag is inverted to form the carry-in, and the flags are inverted as in R2. Example: 0x34−0x12 with C=1 gives 0x21.
- R4: With `borrow_mode`=0, SUB uses carry-in 1 and SBC uses the stored carry flag unchanged. `flag_c` and `flag_h` are then the uninverted adder carries. Example: SUB 0x90−0x92 gives 0xFE with C=0 and H=0.
- R5: `flag_z` is set after an executed edge exactly when the 8-bit result was 0x00, for every operation.
- R6: `flag_n` is set by SUB and SBC and cleared by ADD and ADC.
- R7: The flags change only on a rising edge where `exec_en`=1. When `exec_en`=0 they hold their value.
- R8: A synchronous reset `rst`=1 clears all four flags at the next rising edge.
- R9: `result` is combinational from the inputs and the stored carry flag. It is valid in the same cycle whatever the value of `exec_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears flags |
| exec_en | input | 1 | Execute strobe: capture flags at this edge |
| op | input | 2 | 00 ADD, 01 ADC, 10 SUB, 11 SBC |
| borrow_mode | input | 1 | 1 = borrow convention, 0 = direct carry convention |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand (subtrahend) |
| result | output | 8 | Combinational sum or difference |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered subtract flag |
| flag_h | output | 1 | Registered half-carry flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The embedded properties assume that `op`, `borrow_mode`, `opa`, `opb` and `exec_en` are known, two-state values that are stable around each rising edge. They also assume that `rst` is held high at time zero. The bench meets these assumptions by setting every input before the first edge, holding reset at the start, and changing inputs only on falling edges. Each operation is checked against an arithmetic model in the bench that works out borrows by true subtraction rather than by inverted adder carries. This keeps the carry-convention rules independently checked.

// File: rtl/addsub_alu8_pkg.sv
package addsub_alu8_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_alu8_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_op_e        op_i,
  input  logic           borrow_mode_i,
  input  logic           carry_flag_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   b_eff_o,
  output logic           cin_o
);
  logic is_sub;

  always_comb begin
    is_sub  = op_i[1];
    // subtraction feeds the inverted operand into the shared adder
    b_eff_o = is_sub ? ~b_i : b_i;
    unique case (op_i)
      OP_ADD:  cin_o = 1'b0;
      OP_ADC:  cin_o = carry_flag_i;
      OP_SUB:  cin_o = 1'b1;  // the +1 that completes the negation
      OP_SBC:  cin_o = borrow_mode_i ? ~carry_flag_i : carry_flag_i;
      default: cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_split_adder.sv
module addsub_split_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_half_o,
  output logic         c_full_o
);
  localparam int unsigned HALF_W = W / 2;
  localparam int unsigned HIGH_W = W - HALF_W;

  logic [HALF_W:0] lo_sum;
  logic [HIGH_W:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
           + {{HALF_W{1'b0}}, cin_i};
    hi_sum = {1'b0, a_i[W-1:HALF_W]} + {1'b0, b_i[W-1:HALF_W]}
           + {{HIGH_W{1'b0}}, lo_sum[HALF_W]};
    sum_o    = {hi_sum[HIGH_W-1:0], lo_sum[HALF_W-1:0]};
    c_half_o = lo_sum[HALF_W];
    c_full_o = hi_sum[HIGH_W];
  end
endmodule

// File: rtl/addsub_flag_logic.sv
module addsub_flag_logic
  import addsub_alu8_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_op_e      op_i,
  input  logic         borrow_mode_i,
  input  logic [W-1:0] sum_i,
  input  logic         c_half_i,
  input  logic         c_full_i,
  output alu_flags_t   flags_o
);
  logic invert_carries;

  always_comb begin
    invert_carries = op_i[1] & borrow_mode_i;
    flags_o.z = (sum_i == '0);
    flags_o.n = op_i[1];
    flags_o.h = c_half_i ^ invert_carries;
    flags_o.c = c_full_i ^ invert_carries;
  end
endmodule

// File: rtl/addsub_alu8.sv
module addsub_alu8
  import addsub_alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exec_en,
  input  logic [1:0] op,
  input  logic       borrow_mode,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  output logic [7:0] result,
  output logic       flag_z,
  output logic       flag_n,
  output logic       flag_h,
  output logic       flag_c
);
  localparam int unsigned W = DATA_W;

  alu_op_e      op_e;
  logic [W-1:0] b_eff;
  logic         cin;
  logic         c_half;
  logic         c_full;
  alu_flags_t   next_flags;
  alu_flags_t   flags_q;

  assign op_e = alu_op_e'(op);

  addsub_operand_prep #(.W(W)) u_prep (
    .op_i          (op_e),
    .borrow_mode_i (borrow_mode),
    .carry_flag_i  (flags_q.c),
    .b_i           (opb),
    .b_eff_o       (b_eff),
    .cin_o         (cin)
  );

  addsub_split_adder #(.W(W)) u_adder (
    .a_i      (opa),
    .b_i      (b_eff),
    .cin_i    (cin),
    .sum_o    (result),
    .c_half_o (c_half),
    .c_full_o (c_full)
  );

  addsub_flag_logic #(.W(W)) u_flags (
    .op_i          (op_e),
    .borrow_mode_i (borrow_mode),
    .sum_i         (result),
    .c_half_i      (c_half),
    .c_full_i      (c_full),
    .flags_o       (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= '0;
    else if (exec_en) flags_q <= next_flags;
  end

  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_h = flags_q.h;
  assign flag_c = flags_q.c;

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_q == '0));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(flags_q));

  a_r6_subtract_flag: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_n == $past(op[1])));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_z == ($past(result) == 8'h00)));

  a_r2_borrow_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 2'b10 && borrow_mode) |=> (flag_c == ($past(opa) < $past(opb))));

  a_r4_direct_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 2'b10 && !borrow_mode) |=> (flag_c == ($past(opa) >= $past(opb))));
endmodule

// File: tb/addsub_alu8_tb.sv
`timescale 1ns/1ps
module addsub_alu8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [1:0] op = 2'b00;
  logic       borrow_mode = 1'b1;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic [7:0] result;
  logic       flag_z, flag_n, flag_h, flag_c;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] flags;  // {z,n,h,c}
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  logic [3:0] model_flags = 4'b0000;

  always #2.5 clk = ~clk;

  addsub_alu8 u_dut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op(op), .borrow_mode(borrow_mode),
    .opa(opa), .opb(opb), .result(result),
    .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c)
  );

  // independent arithmetic model: returns {result, z, n, h, c}
  function automatic logic [11:0] model(input logic [1:0] o, input logic m,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic cf);
    int full, lo, cin, bin;
    logic c, h;
    logic [7:0] r;
    if (!o[1]) begin
      cin  = (o == 2'b01) ? int'(cf) : 0;
      full = int'(a) + int'(b) + cin;
      lo   = int'(a[3:0]) + int'(b[3:0]) + cin;
      c = full > 255;
      h = lo > 15;
    end else begin
      if (o == 2'b10) bin = 0;
      else            bin = m ? int'(cf) : int'(!cf);
      full = int'(a) - int'(b) - bin;
      lo   = int'(a[3:0]) - int'(b[3:0]) - bin;
      c = m ? (full < 0) : !(full < 0);
      h = m ? (lo < 0)   : !(lo < 0);
    end
    r = full[7:0];
    return {r, (r == 8'h00), o[1], h, c};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic m, input logic [7:0] a,
                      input logic [7:0] b, input logic ex, input string tag);
    logic [11:0] mv;
    exp_item_t it;
    @(negedge clk);
    rst = 1'b0; op = o; borrow_mode = m; opa = a; opb = b; exec_en = ex;
    #1;
    mv = model(o, m, a, b, model_flags[0]);
    check({tag, " R9 result"}, result, mv[11:4]);
    if (ex) model_flags = mv[3:0];
    it.flags = model_flags; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic reset_cycle();
    exp_item_t it;
    @(negedge clk);
    rst = 1'b1; exec_en = 1'b1;
    model_flags = 4'b0000;
    it.flags = 4'b0000; it.tag = "R8 reset";
    sb_q.push_back(it);
  endtask

  // monitor: compares registered flags after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check({it.tag, " flags"}, {4'b0, flag_z, flag_n, flag_h, flag_c}, {4'b0, it.flags});
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    reset_cycle();
    reset_cycle();
    // R2: borrow-mode SUB examples
    step(2'b10, 1'b1, 8'h90, 8'h92, 1'b1, "R2 sub 90-92");
    step(2'b10, 1'b1, 8'h34, 8'h12, 1'b1, "R2 sub 34-12");
    // R3: SBC with borrow set, then clear
    step(2'b10, 1'b1, 8'h00, 8'h01, 1'b1, "R3 set borrow");
    step(2'b11, 1'b1, 8'h34, 8'h12, 1'b1, "R3 sbc borrow in");
    step(2'b11, 1'b1, 8'h34, 8'h12, 1'b1, "R3 sbc no borrow");
    // R4: direct convention
    step(2'b10, 1'b0, 8'h90, 8'h92, 1'b1, "R4 direct sub 90-92");
    step(2'b11, 1'b0, 8'h34, 8'h12, 1'b1, "R4 direct sbc c0");
    step(2'b11, 1'b0, 8'h34, 8'h12, 1'b1, "R4 direct sbc c1");
    // R1: add / add with carry
    step(2'b00, 1'b1, 8'hFF, 8'h01, 1'b1, "R1 R5 add wrap zero");
    step(2'b01, 1'b1, 8'h0F, 8'h00, 1'b1, "R1 adc half carry");
    step(2'b01, 1'b0, 8'h7F, 8'h80, 1'b1, "R1 adc direct mode");
    // R5 / R6: zero from subtraction, N set
    step(2'b10, 1'b1, 8'h5A, 8'h5A, 1'b1, "R5 R6 sub equal");
    // R7: strobe low leaves flags alone, result still live (R9)
    step(2'b00, 1'b1, 8'h01, 8'h01, 1'b0, "R7 idle add");
    step(2'b10, 1'b1, 8'h00, 8'hFF, 1'b0, "R7 idle sub");
    // R8: mid-run reset after flags set
    step(2'b10, 1'b1, 8'h00, 8'h01, 1'b1, "R8 preset flags");
    reset_cycle();
    step(2'b00, 1'b1, 8'h10, 8'h20, 1'b0, "R8 post reset idle");
    // sweep of mixed patterns
    for (int i = 0; i < 64; i++) begin
      step(2'(i % 4), 1'((i / 4) % 2), 8'(i * 37 + 11), 8'(i * 59 + 3), 1'b1, "R1 R2 R3 R4 sweep");
    end
    @(negedge clk);
    exec_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule